// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (a clock line and a data line). It holds a small bank of 8-bit configuration registers, such as output-enable bits, and presents them on a parallel bus to the logic around it. At reset every register loads a fixed default. Software therefore has to use the bus only when it wants to change a default. A host can read or write one register at a chosen offset. It can also move a run of registers starting at register 0 in a single transaction.

The bus lines are sampled on the system clock through a small synchronizer. Both lines are inputs. The slave pulls the data line low by raising an output-enable, which stands in for an open-drain pad.

The first byte after the address is the command. Its top bit picks single-register access, in which case the low seven bits give the offset. When the top bit is clear, the transfer is a counted block that starts at register 0. A block write carries a count byte before its data. A block read returns the register count before the data.

Top module: `smb_regfile_slave`

## Requirements
- R1: After reset every register holds its default value from the RST_VAL parameter (register k in bits 8k+7:8k) and sda_oe is low.
- R2: The slave acknowledges only the address byte 0xD2 (write) or 0xD3 (read), which is a 7-bit address of 0x69 followed by a read/write bit where 1 means read. Any other address is not acknowledged, and every further byte up to the next start condition is ignored and not acknowledged.
- R3: A command with bit 7 set selects a single register at the offset in bits 6:0. In a write, exactly one data byte is stored there. A second data byte is not acknowledged and not stored.
- R4: A single-register read consists of: command, repeated start, 0xD3. The slave then returns the addressed register, most significant bit first.
- R5: A command with bit 7 clear starts a block write. The next byte is a count. Data bytes are then stored into registers 0, 1, 2 and so on, each acknowledged, while the count is not used up and the index is below NREG. Bytes beyond that limit are not acknowledged and not stored. A stop after any whole byte keeps all bytes stored up to that point.
- R6: A block read consists of: block command, repeated start, 0xD3. The slave returns the value NREG first, then register 0 upward, one byte for each master acknowledge. A master not-acknowledge ends the transfer and the data line is released.
- R7: A single-register command whose offset is NREG or larger is not acknowledged, and no register changes.
- R8: The slave holds sda_oe high through the ninth clock that follows each address, command, count or data byte it accepts, and releases it after that clock's falling edge. sda_oe changes only while the synchronized clock line is low.
- R9: A start condition is a falling data line while the clock line is high. It restarts the address phase from any state, which makes a repeated start valid before the read address. A stop condition is a rising data line while the clock line is high, and it returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are oversampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| regs_o | output | NREG*8 | All configuration registers; register k in bits 8k+7:8k |

## Verification
A wrong byte position or pointer inside the slave shows up at the ports within one byte time. The read data shifted out on the data line differs from the bench's register model, or the parallel register bus changes a byte that the host never addressed. A stale acknowledge state shows as sda_oe still high when the next bit starts, or as a missing low level in the middle of the ninth clock. The bench samples both of these on every bit. A state machine that fails to return to idle keeps answering bytes after a refused address or an over-long write. The bench sees this at the acknowledge bit of the very next byte.

// File: rtl/smb_pkg.sv
package smb_pkg;
   // bit-level engine states
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } st_e;

   // meaning of the byte currently being received
   typedef enum logic [1:0] {
      RL_ADDR,
      RL_CMD,
      RL_CNT,
      RL_DATA
   } role_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   initial begin
      if (STAGES < 2) $fatal(1, "smb_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_sr, sda_sr;
   logic              scl_d, sda_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_sr <= '1;
         sda_sr <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sr <= {scl_sr[STAGES-2:0], scl_i};
         sda_sr <= {sda_sr[STAGES-2:0], sda_i};
         scl_d  <= scl_q;
         sda_d  <= sda_q;
      end
   end

   assign scl_q     = scl_sr[STAGES-1];
   assign sda_q     = sda_sr[STAGES-1];
   assign scl_rise  = scl_q & ~scl_d;
   assign scl_fall  = ~scl_q & scl_d;
   assign start_evt = scl_q & scl_d & sda_d & ~sda_q;
   assign stop_evt  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
   parameter int                NREG    = 8,
   parameter int                IW      = 3,
   parameter logic [NREG*8-1:0] RST_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_idx,
   input  logic [7:0]        wr_data,
   output logic [NREG*8-1:0] regs_o
);
   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               regs_o[g*8 +: 8] <= RST_VAL[g*8 +: 8];
            else if (wr_en && (int'(wr_idx) == g))
               regs_o[g*8 +: 8] <= wr_data;
         end
      end
   endgenerate
endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
   import smb_pkg::*;
#(
   parameter int         NREG     = 8,
   parameter logic [6:0] DEV_ADDR = 7'h69,
   parameter int         IW       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              sda_q,
   input  logic [NREG*8-1:0] regs_i,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [IW-1:0]     wr_idx,
   output logic [7:0]        wr_data,
   output role_e             role_o
);
   localparam logic [7:0] NREG_B = 8'(NREG);

   st_e        st;
   role_e      role;
   logic [3:0] bcnt;
   logic [7:0] sh, tsh, ptr, left, tx_next;
   logic       rd_mode, cnt_due, mack, accept, ptr_ok;
   logic [7:0] regv [NREG];

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_view
         assign regv[g] = regs_i[g*8 +: 8];
      end
   endgenerate

   assign ptr_ok = ptr < NREG_B;

   always_comb begin
      case (role)
         RL_ADDR: accept = (sh[7:1] == DEV_ADDR);
         RL_CMD:  accept = !sh[7] || ({1'b0, sh[6:0]} < NREG_B);
         RL_CNT:  accept = 1'b1;
         default: accept = (left != 8'd0) && ptr_ok;
      endcase
      if (cnt_due)     tx_next = NREG_B;
      else if (ptr_ok) tx_next = regv[ptr[IW-1:0]];
      else             tx_next = 8'hFF;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         role    <= RL_ADDR;
         bcnt    <= '0;
         sh      <= '0;
         tsh     <= '1;
         ptr     <= '0;
         left    <= '0;
         rd_mode <= 1'b0;
         cnt_due <= 1'b0;
         mack    <= 1'b0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_evt) begin
            st      <= ST_RX;
            role    <= RL_ADDR;
            bcnt    <= '0;
            rd_mode <= 1'b0;
         end else if (stop_evt) begin
            st <= ST_IDLE;
         end else begin
            case (st)
               ST_RX: begin
                  if (scl_rise && bcnt != 4'd8) begin
                     sh   <= {sh[6:0], sda_q};
                     bcnt <= bcnt + 4'd1;
                  end else if (scl_fall && bcnt == 4'd8) begin
                     bcnt <= '0;
                     st   <= accept ? ST_ACK : ST_IDLE;
                     if (accept) begin
                        case (role)
                           RL_ADDR: begin
                              rd_mode <= sh[0];
                              role    <= RL_CMD;
                           end
                           RL_CMD: begin
                              ptr     <= sh[7] ? {1'b0, sh[6:0]} : 8'd0;
                              left    <= 8'd1;
                              cnt_due <= ~sh[7];
                              role    <= sh[7] ? RL_DATA : RL_CNT;
                           end
                           RL_CNT: begin
                              left <= sh;
                              role <= RL_DATA;
                           end
                           default: begin
                              wr_en   <= 1'b1;
                              wr_idx  <= ptr[IW-1:0];
                              wr_data <= sh;
                              ptr     <= ptr + 8'd1;
                              left    <= left - 8'd1;
                           end
                        endcase
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     if (rd_mode) begin
                        st   <= ST_TX;
                        tsh  <= tx_next;
                        bcnt <= '0;
                        if (cnt_due)     cnt_due <= 1'b0;
                        else if (ptr_ok) ptr     <= ptr + 8'd1;
                     end else begin
                        st <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bcnt == 4'd7) begin
                        st   <= ST_MACK;
                        bcnt <= '0;
                        tsh  <= '1;
                     end else begin
                        bcnt <= bcnt + 4'd1;
                        tsh  <= {tsh[6:0], 1'b1};
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_q;
                  end else if (scl_fall) begin
                     if (mack) begin
                        st   <= ST_TX;
                        tsh  <= tx_next;
                        bcnt <= '0;
                        if (cnt_due)     cnt_due <= 1'b0;
                        else if (ptr_ok) ptr     <= ptr + 8'd1;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_oe = (st == ST_ACK) || ((st == ST_TX) && !tsh[7]);
   assign role_o = role;
endmodule

// File: rtl/smb_regfile_slave.sv
module smb_regfile_slave
   import smb_pkg::*;
#(
   parameter int                NREG        = 8,
   parameter logic [6:0]        DEV_ADDR    = 7'h69,
   parameter int                SYNC_STAGES = 2,
   parameter logic [NREG*8-1:0] RST_VAL     = {NREG{8'hFF}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [NREG*8-1:0] regs_o
);
   localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

   initial begin
      if (NREG < 1 || NREG > 128)
         $fatal(1, "smb_regfile_slave: NREG must lie in 1..128");
   end

   logic          scl_q, sda_q, scl_rise, scl_fall, start_evt, stop_evt;
   logic          wr_en;
   logic [IW-1:0] wr_idx;
   logic [7:0]    wr_data;
   role_e         role;

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt)
   );

   smb_slave_fsm #(.NREG(NREG), .DEV_ADDR(DEV_ADDR), .IW(IW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt), .sda_q(sda_q),
      .regs_i(regs_o), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .role_o(role)
   );

   smb_reg_bank #(.NREG(NREG), .IW(IW), .RST_VAL(RST_VAL)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .regs_o(regs_o)
   );
endmodule

// File: rtl/smb_regfile_slave_chk.sv
module smb_regfile_slave_chk
   import smb_pkg::*;
#(
   parameter int NREG = 8,
   parameter int IW   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_q,
   input logic              sda_oe,
   input logic              start_evt,
   input logic              stop_evt,
   input logic              wr_en,
   input logic [IW-1:0]     wr_idx,
   input logic [NREG*8-1:0] regs_o,
   input logic [1:0]        role
);
   // R8: the data line is only pulled or released while the clock is low
   p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_q);

   // R5: the register bus moves only after a write strobe from the engine
   p_regs_by_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs_o) |-> $past(wr_en));

   // R7: a write strobe never targets a register outside the bank
   p_idx_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < NREG));

   // R9: a start condition always reopens the address phase
   p_start_to_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> (role == 2'(RL_ADDR)));

   // R6: after a stop the slave has let go of the data line
   p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe);
endmodule

bind smb_regfile_slave smb_regfile_slave_chk #(.NREG(NREG), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_oe(sda_oe),
   .start_evt(start_evt), .stop_evt(stop_evt), .wr_en(wr_en),
   .wr_idx(wr_idx), .regs_o(regs_o), .role(role)
);

// File: tb/smb_regfile_slave_tb.sv
module smb_regfile_slave_tb;
   localparam int             CLK_P = 10;
   localparam int             Q     = 4;
   localparam int             NREG  = 8;
   localparam logic [63:0]    RST   = 64'h7E6D_5C4B_3A29_18A5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_low = 1'b0;
   logic sda_bus, sda_oe;
   logic [NREG*8-1:0] regs_o;
   logic [7:0] mdl [NREG];
   bit cmp_en = 1'b0;
   bit done = 1'b0;
   int vec = 0;
   int fails = 0;

   always #(CLK_P/2) clk = ~clk;
   assign sda_bus = ~(m_low | sda_oe);

   smb_regfile_slave #(.NREG(NREG), .RST_VAL(RST)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .sda_oe(sda_oe), .regs_o(regs_o)
   );

   function automatic logic [NREG*8-1:0] mdl_bus();
      logic [NREG*8-1:0] b;
      for (int i = 0; i < NREG; i++) b[i*8 +: 8] = mdl[i];
      return b;
   endfunction

   // per-clock comparison of the register bus and the released line
   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         vec++;
         if (regs_o !== mdl_bus() || sda_oe !== 1'b0) begin
            fails++;
            $display("FAIL R5 idle compare: actual regs=%h oe=%b expected regs=%h oe=0",
                     regs_o, sda_oe, mdl_bus());
         end
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      vec++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wcyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_io(input logic b, output logic rd);
      m_low = ~b;
      wcyc(Q); scl = 1'b1;
      wcyc(Q); rd = sda_bus;
      wcyc(Q); scl = 1'b0;
      wcyc(Q);
   endtask

   task automatic bus_start();
      cmp_en = 1'b0;
      m_low = 1'b1; wcyc(Q);
      scl = 1'b0;   wcyc(Q);
   endtask

   task automatic bus_rstart();
      m_low = 1'b0; wcyc(Q);
      scl = 1'b1;   wcyc(Q);
      m_low = 1'b1; wcyc(Q);
      scl = 1'b0;   wcyc(Q);
   endtask

   task automatic bus_stop();
      m_low = 1'b1; wcyc(Q);
      scl = 1'b1;   wcyc(Q);
      m_low = 1'b0; wcyc(2*Q);
      cmp_en = 1'b1;
   endtask

   // sends a byte; returns 1 when the slave acknowledged
   task automatic send(input logic [7:0] b, output logic ackd, input bit rel_chk);
      logic d;
      for (int i = 7; i >= 0; i--) bit_io(b[i], d);
      bit_io(1'b1, d);
      ackd = ~d;
      if (rel_chk && ackd) chk("R8 release after ack", {7'd0, sda_oe}, 8'd0);
   endtask

   task automatic recv(output logic [7:0] b, input bit give_ack);
      logic d;
      for (int i = 7; i >= 0; i--) begin
         bit_io(1'b1, d);
         b[i] = d;
      end
      bit_io(~give_ack, d);
   endtask

   task automatic wr_one(input logic [7:0] off, input logic [7:0] d);
      logic a;
      bus_start();
      send(8'hD2, a, 1'b1);            chk("R2 write address ack", {7'd0, a}, 8'd1);
      send({1'b1, off[6:0]}, a, 1'b1); chk("R3 byte command ack", {7'd0, a}, 8'd1);
      send(d, a, 1'b1);                chk("R8 data ack", {7'd0, a}, 8'd1);
      mdl[off[2:0]] = d;
      bus_stop();
   endtask

   task automatic rd_one(input logic [7:0] off);
      logic a;
      logic [7:0] b;
      bus_start();
      send(8'hD2, a, 1'b1);
      send({1'b1, off[6:0]}, a, 1'b1);
      bus_rstart();
      send(8'hD3, a, 1'b0);            chk("R9 read address after repeated start", {7'd0, a}, 8'd1);
      recv(b, 1'b0);                   chk("R4 byte read data", b, mdl[off[2:0]]);
      bus_stop();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] b;
      for (int i = 0; i < NREG; i++) mdl[i] = RST[i*8 +: 8];
      wcyc(5);
      rst_n = 1'b1;
      wcyc(2);
      // R1 reset state
      for (int i = 0; i < NREG; i++) chk("R1 reset value", regs_o[i*8 +: 8], RST[i*8 +: 8]);
      chk("R1 line released", {7'd0, sda_oe}, 8'd0);
      cmp_en = 1'b1;
      wcyc(4);

      // R3/R4 single register write and read back, including last register
      wr_one(8'd3, 8'h5C);
      rd_one(8'd3);
      rd_one(8'd0);
      wr_one(8'd7, 8'hE1);
      rd_one(8'd7);

      // R2 foreign address is refused and the rest of the frame ignored
      bus_start();
      send(8'hA0, a, 1'b0); chk("R2 foreign address nack", {7'd0, a}, 8'd0);
      send(8'h83, a, 1'b0); chk("R2 ignored command", {7'd0, a}, 8'd0);
      send(8'h77, a, 1'b0); chk("R2 ignored data", {7'd0, a}, 8'd0);
      bus_stop();

      // R3 second data byte in a single-register write is refused
      bus_start();
      send(8'hD2, a, 1'b1);
      send(8'h85, a, 1'b1);
      send(8'h11, a, 1'b1); chk("R3 first data ack", {7'd0, a}, 8'd1);
      send(8'h22, a, 1'b0); chk("R3 second data nack", {7'd0, a}, 8'd0);
      mdl[5] = 8'h11;
      bus_stop();

      // R7 offset beyond the bank
      bus_start();
      send(8'hD2, a, 1'b1);
      send(8'h88, a, 1'b0); chk("R7 out-of-range offset nack", {7'd0, a}, 8'd0);
      send(8'h99, a, 1'b0); chk("R7 following byte nack", {7'd0, a}, 8'd0);
      bus_stop();

      // R5 block write limited by the count byte
      bus_start();
      send(8'hD2, a, 1'b1);
      send(8'h00, a, 1'b1); chk("R5 block command ack", {7'd0, a}, 8'd1);
      send(8'd3, a, 1'b1);  chk("R5 count ack", {7'd0, a}, 8'd1);
      send(8'hAA, a, 1'b1); chk("R5 block data 0 ack", {7'd0, a}, 8'd1);
      send(8'hBB, a, 1'b1); chk("R5 block data 1 ack", {7'd0, a}, 8'd1);
      send(8'hCC, a, 1'b1); chk("R5 block data 2 ack", {7'd0, a}, 8'd1);
      send(8'hDD, a, 1'b0); chk("R5 beyond count nack", {7'd0, a}, 8'd0);
      mdl[0] = 8'hAA; mdl[1] = 8'hBB; mdl[2] = 8'hCC;
      bus_stop();

      // R5 block write stopped early
      bus_start();
      send(8'hD2, a, 1'b1);
      send(8'h00, a, 1'b1);
      send(8'd5, a, 1'b1);
      send(8'h12, a, 1'b1);
      send(8'h34, a, 1'b1); chk("R5 early-stop data ack", {7'd0, a}, 8'd1);
      mdl[0] = 8'h12; mdl[1] = 8'h34;
      bus_stop();

      // R6 full block read
      bus_start();
      send(8'hD2, a, 1'b1);
      send(8'h00, a, 1'b1);
      bus_rstart();
      send(8'hD3, a, 1'b0); chk("R9 block read address ack", {7'd0, a}, 8'd1);
      recv(b, 1'b1);        chk("R6 count byte", b, 8'(NREG));
      for (int i = 0; i < NREG; i++) begin
         recv(b, i != NREG - 1);
         chk("R6 block read data", b, mdl[i]);
      end
      chk("R6 released after master nack", {7'd0, sda_oe}, 8'd0);
      bus_stop();

      // R6 block read ended early by the master
      bus_start();
      send(8'hD2, a, 1'b1);
      send(8'h00, a, 1'b1);
      bus_rstart();
      send(8'hD3, a, 1'b0);
      recv(b, 1'b1);  chk("R6 count byte again", b, 8'(NREG));
      recv(b, 1'b1);  chk("R6 partial data 0", b, mdl[0]);
      recv(b, 1'b0);  chk("R6 partial data 1", b, mdl[1]);
      chk("R6 released after early nack", {7'd0, sda_oe}, 8'd0);
      bus_stop();

      rd_one(8'd5);
      rd_one(8'd2);
      wcyc(10);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
      $finish;
   end
endmodule